// File: doc/BRIEF.md
# Keyed Unlock Guard for a Flash Control Register

This block sits on the register bus in front of a flash controller and decides whether software may change the controller's settings. It leaves reset with the control register shut. Software opens it by writing two fixed 32-bit magic words, in a fixed order, to a key address. Any slip in that ritual trips a hard lockout. The lockout is cleared only by reset, and while it holds every flash operation must be refused. Software may close the control register again at any time by writing a one to a lock bit in a second control word.

A separate option-byte key address takes the same two magic words and, when the main register is already open, raises an option-byte write enable. Software can drop that enable with a write-one-to-clear bit. The block also keeps an operation-complete flag. A pulse from the flash engine sets the flag when an option-byte erase or program finishes, and the flag drives an interrupt through an enable bit.

The block has a plain write port and a set of status outputs. The flash engine reads `hard_lock` as its refuse-everything signal and `ob_wen` as its permission to touch option bytes.

Top module: `flash_key_guard`

## Requirements
- R1: After reset, `locked`=1, `hard_lock`=0, `ob_wen`=0, `ctrl_q`=0, `op_cmpl`=0 and `irq`=0.
- R2: While `locked` is 1, a write to the control address (CTRL_A, default 2) leaves `ctrl_q` unchanged. This includes the cycle after only the first key has been accepted.
- R3: Writing 0x45670123 and then 0xCDEF89AB to the key address (KEY_A, default 0) clears `locked` one cycle after the second write. A later control write then loads `wr_data[CTRL_W-1:0]` into `ctrl_q`.
- R4: Any of the following at the key address sets `hard_lock` one cycle after the write: a first key other than 0x45670123, or a second key other than 0xCDEF89AB. Giving the second key first counts as a wrong first key.
- R5: A key-address write while `locked` is 0 sets `hard_lock`.
- R6: Once set, `hard_lock` stays set until reset. While it is set, `locked`=1 and `ob_wen`=0, and key, option-key and control writes have no effect.
- R7: Writing a 1 in bit 0 of the second control word (CTRL2_A, default 3) sets `locked` on the next cycle. A fresh two-key sequence then opens the register again.
- R8: While `locked` is 0, writing 0x45670123 and then 0xCDEF89AB to the option-key address (OBKEY_A, default 1) sets `ob_wen`. A wrong word in this sequence sets `hard_lock`.
- R9: Any option-key write while `locked` is 1 sets `hard_lock`.
- R10: Writing a 1 in bit 1 of the second control word clears `ob_wen`. No control-word write can set `ob_wen`.
- R11: A cycle with `ob_op_done`=1 sets `op_cmpl`. Writing a 1 in bit 3 of the second control word clears it, but a completion pulse in the same cycle wins.
- R12: Bit 2 of every second-control-word write is stored as the interrupt enable. `irq` is 1 exactly when `op_cmpl` and that enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| ob_op_done | input | 1 | Pulse from the flash engine when an option-byte erase or program finishes |
| ctrl_q | output | CTRL_W | Contents of the guarded control register |
| locked | output | 1 | Control register closed to writes |
| hard_lock | output | 1 | Lockout after a key error; all flash operations refused |
| ob_wen | output | 1 | Option-byte program/erase enabled |
| op_cmpl | output | 1 | Operation-complete flag |
| irq | output | 1 | Completion interrupt |

## Verification
The bench checks that a control write placed between the two keys is dropped. A design that opened the register on the first key would load that value. The bench also tries the second key first, repeats the first key, and writes a key to an already open register. A guard that only compared values, or that ignored order, would stay out of lockout in those cases. It then feeds the correct keys after a lockout. A lockout that a good sequence could clear would reopen the register. Finally it runs a completion pulse and a clear of the flag in the same cycle, and drops the write enable with the interrupt enable both set and cleared. This catches a clear that beats the set, or a write enable tied to the wrong bit.

// File: rtl/flash_key_guard.sv
module flash_key_guard #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CTRL_W = 16,
  parameter logic [ADDR_W-1:0] KEY_A   = 'd0,
  parameter logic [ADDR_W-1:0] OBKEY_A = 'd1,
  parameter logic [ADDR_W-1:0] CTRL_A  = 'd2,
  parameter logic [ADDR_W-1:0] CTRL2_A = 'd3,
  parameter logic [DATA_W-1:0] KEY1 = 32'h4567_0123,
  parameter logic [DATA_W-1:0] KEY2 = 32'hCDEF_89AB,
  parameter int unsigned LOCK_BIT   = 0,
  parameter int unsigned OBCLR_BIT  = 1,
  parameter int unsigned IE_BIT     = 2,
  parameter int unsigned OPCCLR_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ob_op_done,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              locked,
  output logic              hard_lock,
  output logic              ob_wen,
  output logic              op_cmpl,
  output logic              irq
);

  typedef enum logic [1:0] {S_SHUT, S_HALF, S_OPEN} key_st_t;

  key_st_t key_st;
  logic    ob_half;
  logic    irq_en;

  wire key_wr   = wr_en && (wr_addr == KEY_A);
  wire obkey_wr = wr_en && (wr_addr == OBKEY_A);
  wire ctrl_wr  = wr_en && (wr_addr == CTRL_A);
  wire ctrl2_wr = wr_en && (wr_addr == CTRL2_A);

  wire is_open = (key_st == S_OPEN) && !hard_lock;

  wire key_bad = key_wr && ((key_st == S_OPEN) ||
                            (key_st == S_SHUT && wr_data != KEY1) ||
                            (key_st == S_HALF && wr_data != KEY2));
  wire ob_bad  = obkey_wr && (!is_open ||
                              (!ob_half && wr_data != KEY1) ||
                              (ob_half && wr_data != KEY2));
  wire trip    = !hard_lock && (key_bad || ob_bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_st    <= S_SHUT;
      ob_half   <= 1'b0;
      ob_wen    <= 1'b0;
      hard_lock <= 1'b0;
      ctrl_q    <= '0;
    end else if (trip) begin
      hard_lock <= 1'b1;
      key_st    <= S_SHUT;
      ob_half   <= 1'b0;
      ob_wen    <= 1'b0;
    end else if (!hard_lock) begin
      if (key_wr)
        key_st <= (key_st == S_SHUT) ? S_HALF : S_OPEN;
      if (obkey_wr) begin
        if (ob_half) begin
          ob_wen  <= 1'b1;
          ob_half <= 1'b0;
        end else begin
          ob_half <= 1'b1;
        end
      end
      if (ctrl_wr && is_open)
        ctrl_q <= wr_data[CTRL_W-1:0];
      if (ctrl2_wr) begin
        if (wr_data[LOCK_BIT]) begin
          key_st  <= S_SHUT;
          ob_half <= 1'b0;
        end
        if (wr_data[OBCLR_BIT])
          ob_wen <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en  <= 1'b0;
      op_cmpl <= 1'b0;
    end else begin
      if (ctrl2_wr)
        irq_en <= wr_data[IE_BIT];
      if (ob_op_done)
        op_cmpl <= 1'b1;
      else if (ctrl2_wr && wr_data[OPCCLR_BIT])
        op_cmpl <= 1'b0;
    end
  end

  assign locked = hard_lock || (key_st != S_OPEN);
  assign irq    = op_cmpl & irq_en;

endmodule

module flash_key_guard_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CTRL_W = 16,
  parameter logic [ADDR_W-1:0] KEY_A   = 'd0,
  parameter logic [ADDR_W-1:0] OBKEY_A = 'd1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              locked,
  input logic              hard_lock,
  input logic              ob_wen,
  input logic              op_cmpl,
  input logic              irq
);

  a_r2_ctrl_frozen_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(ctrl_q));

  a_r5_key_while_open: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == KEY_A && !locked) |=> hard_lock);

  a_r6_hard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hard_lock |=> hard_lock);

  a_r6_hard_closes_all: assert property (@(posedge clk) disable iff (!rst_n)
    hard_lock |-> (locked && !ob_wen));

  a_r9_obkey_while_shut: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OBKEY_A && locked) |=> hard_lock);

  a_r8_wen_rises_open: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ob_wen) |-> $past(!locked));

  a_r12_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !op_cmpl |-> !irq);

endmodule

bind flash_key_guard flash_key_guard_chk #(
  .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .KEY_A(KEY_A), .OBKEY_A(OBKEY_A)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .ctrl_q(ctrl_q), .locked(locked), .hard_lock(hard_lock),
  .ob_wen(ob_wen), .op_cmpl(op_cmpl), .irq(irq)
);

// File: tb/flash_key_guard_test.sv
module flash_key_guard_test;
  localparam int CLK_P = 10;
  localparam logic [3:0] A_KEY = 4'd0, A_OBK = 4'd1, A_CTL = 4'd2, A_CT2 = 4'd3;
  localparam logic [31:0] K1 = 32'h4567_0123, K2 = 32'hCDEF_89AB;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, ob_op_done = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] ctrl_q;
  logic locked, hard_lock, ob_wen, op_cmpl, irq;

  always #(CLK_P/2) clk = ~clk;

  flash_key_guard uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ob_op_done(ob_op_done), .ctrl_q(ctrl_q),
    .locked(locked), .hard_lock(hard_lock), .ob_wen(ob_wen),
    .op_cmpl(op_cmpl), .irq(irq)
  );

  typedef struct {
    logic [15:0] ctrl;
    logic lk, hd, wen, opc, irq;
    string tag;
  } exp_t;

  exp_t sb[$];
  int vectors = 0, miscompares = 0;
  bit finished = 0;

  int m_st;
  bit m_hard, m_obh, m_wen, m_ie, m_opc;
  logic [15:0] m_ctrl;

  task automatic model_reset();
    m_st = 0; m_hard = 0; m_obh = 0; m_wen = 0; m_ie = 0; m_opc = 0; m_ctrl = '0;
  endtask

  task automatic step(bit we, logic [3:0] a, logic [31:0] d, bit done, string tag);
    exp_t e;
    bit bad = 0;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; ob_op_done = done;
    if (we && !m_hard) begin
      case (a)
        A_KEY: begin
          if (m_st == 0 && d == K1) m_st = 1;
          else if (m_st == 1 && d == K2) m_st = 2;
          else bad = 1;
        end
        A_OBK: begin
          if (m_st != 2) bad = 1;
          else if (!m_obh) begin if (d == K1) m_obh = 1; else bad = 1; end
          else begin if (d == K2) begin m_wen = 1; m_obh = 0; end else bad = 1; end
        end
        A_CTL: if (m_st == 2) m_ctrl = d[15:0];
        A_CT2: begin
          if (d[0]) begin m_st = 0; m_obh = 0; end
          if (d[1]) m_wen = 0;
        end
        default: ;
      endcase
    end
    if (bad) begin m_hard = 1; m_st = 0; m_obh = 0; m_wen = 0; end
    if (we && a == A_CT2) m_ie = d[2];
    if (done) m_opc = 1;
    else if (we && a == A_CT2 && d[3]) m_opc = 0;
    e.ctrl = m_ctrl; e.lk = m_hard || m_st != 2; e.hd = m_hard; e.wen = m_wen;
    e.opc = m_opc; e.irq = m_opc & m_ie; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(string tag);
    step(0, 4'd0, 32'd0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; ob_op_done = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      vectors++;
      if (ctrl_q !== e.ctrl || locked !== e.lk || hard_lock !== e.hd ||
          ob_wen !== e.wen || op_cmpl !== e.opc || irq !== e.irq) begin
        miscompares++;
        $display("FAIL %s: got ctrl=%h lk=%b hd=%b wen=%b opc=%b irq=%b, expected ctrl=%h lk=%b hd=%b wen=%b opc=%b irq=%b",
                 e.tag, ctrl_q, locked, hard_lock, ob_wen, op_cmpl, irq,
                 e.ctrl, e.lk, e.hd, e.wen, e.opc, e.irq);
      end
    end
  end

  initial begin
    #(CLK_P*5000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    idle("R1 reset state");
    step(1, A_CTL, 32'h1234, 0, "R2 ctrl write while shut");
    step(1, A_KEY, K1, 0, "R3 first key");
    step(1, A_CTL, 32'h0055, 0, "R2 ctrl write after first key only");
    step(1, A_KEY, K2, 0, "R3 second key opens");
    step(1, A_CTL, 32'hBEEF, 0, "R3 ctrl write while open");
    step(1, A_OBK, K1, 0, "R8 option first key");
    step(1, A_OBK, K2, 0, "R8 option second key sets wen");
    step(1, A_CT2, 32'h4, 0, "R12 enable irq, wen kept");
    step(0, 4'd0, 32'd0, 1, "R11 completion sets flag, R12 irq");
    step(1, A_CT2, 32'hC, 1, "R11 set wins over clear");
    step(1, A_CT2, 32'hC, 0, "R11 clear flag");
    step(1, A_CT2, 32'h2, 0, "R10 clear wen");
    step(0, 4'd0, 32'd0, 1, "R12 flag without enable gives no irq");
    step(1, A_CT2, 32'h8, 0, "R11 clear again");
    step(1, A_CT2, 32'h0, 0, "R10 ctrl2 write cannot set wen");
    step(1, A_CT2, 32'h1, 0, "R7 lock bit closes");
    step(1, A_CTL, 32'h7777, 0, "R7 ctrl write ignored after relock");
    step(1, A_KEY, K1, 0, "R7 reopen first key");
    step(1, A_KEY, K2, 0, "R7 reopen second key");
    step(1, A_CTL, 32'h0A0A, 0, "R7 ctrl write after reopen");
    step(1, A_OBK, K1, 0, "R6 option first key");
    step(1, A_OBK, K2, 0, "R6 wen set before lockout");
    step(1, A_KEY, K1, 0, "R5 key write while open trips");
    step(1, A_KEY, K1, 0, "R6 keys ignored in lockout");
    step(1, A_KEY, K2, 0, "R6 second key ignored in lockout");
    step(1, A_CTL, 32'h3333, 0, "R6 ctrl write ignored in lockout");
    step(1, A_CT2, 32'h1, 0, "R6 lock bit no effect in lockout");

    do_reset();
    idle("R1 reset clears lockout");
    step(1, A_KEY, 32'h0, 0, "R4 wrong first key");
    do_reset();
    step(1, A_KEY, K2, 0, "R4 second key given first");
    do_reset();
    step(1, A_KEY, K1, 0, "R4 first key");
    step(1, A_KEY, K1, 0, "R4 first key repeated");
    do_reset();
    step(1, A_OBK, K1, 0, "R9 option key while shut");
    do_reset();
    step(1, A_KEY, K1, 0, "R9 first main key");
    step(1, A_OBK, K1, 0, "R9 option key while half open");
    do_reset();
    step(1, A_KEY, K1, 0, "R8 open first");
    step(1, A_KEY, K2, 0, "R8 open second");
    step(1, A_OBK, K1, 0, "R8 option first key");
    step(1, A_OBK, K1, 0, "R8 wrong option second key trips");
    idle("R6 lockout holds");
    idle("R6 final");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule